// File: doc/BRIEF.md
# Seven-to-One Serial Video Deserializer

This block turns five serial video lanes back into parallel pixel words. A bit-rate clock running at seven times the pixel rate has already sampled every lane into the digital domain, so each clock cycle brings one bit from each of the five data lanes and one bit from a framing lane. The framing lane repeats a fixed seven-bit high/low shape once per pixel period. The block searches that shape for the word boundary and, once it is locked, rebuilds a 35-bit word every seven cycles. It also produces a pixel-rate clock that is high for four bit-cycles and low for three.

Output words can be launched on either edge of the pixel clock. A power-down input and a reserved input each hold the block inactive, clear its alignment and force its outputs low. The output-enable input drives a pad-enable output that tri-states the data pads, which sit outside this block. Out of the 35 bits, thirty are colour data and five carry horizontal sync, vertical sync, data enable and two general control bits. The block passes all 35 bits through unchanged.

Top module: `desr_7to1`

## Requirements
- R1: Lane L (0 to 4) delivers bit b (0 to 6) of its seven-bit group on `pix_word[7*L + b]`, and the value in that position is the value that was serialised.
- R2: Within each period, every lane and the framing lane send bit 6 first and bit 0 last. The framing lane carries the pattern 1100011, written with the first-sent bit on the left. The period boundary is the edge that samples bit 0.
- R3: Lock is declared at the third consecutive period whose framing bits match the pattern. Until then `pix_word` is all zero and `pix_clk` is low.
- R4: While locked, one or two consecutive periods with a wrong framing pattern do not disturb the output. A third consecutive wrong period drops lock, forces the outputs low, and a new three-period acquisition then starts.
- R5: With `edge_sel` high, the word whose bit 0 is sampled at the boundary of period k appears at the boundary edge that ends period k+2, where `pix_clk` rises. It holds until the next rise.
- R6: With `edge_sel` low, that word appears at the edge that ends the fourth bit-cycle of period k+2, where `pix_clk` falls. It holds until the next fall.
- R7: While locked, `pix_clk` is high for the first four bit-cycles of each period and low for the last three.
- R8: While `pwr_on` is low, `pix_word` and `pix_clk` are low and all internal state is cleared. After `pwr_on` returns high at a period start, lock is regained at the third period boundary.
- R9: While `rsvd_in` is high, the block behaves as it does with `pwr_on` low.
- R10: `pix_oe` follows `out_en`. The data path and alignment are not affected by `out_en`.
- R11: While `rst_n` is low at a clock edge, all state is cleared and `pix_word` and `pix_clk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven times the pixel rate |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_lane | input | 5 | One sampled serial bit per data lane |
| ser_frame | input | 1 | Sampled bit of the framing lane |
| edge_sel | input | 1 | 1: launch on pixel-clock rise, 0: on fall |
| pwr_on | input | 1 | 0 holds the block inactive |
| out_en | input | 1 | Data pad enable request |
| rsvd_in | input | 1 | Must be 0; 1 holds the block inactive |
| pix_word | output | 35 | Recovered parallel word |
| pix_clk | output | 1 | Pixel-rate clock |
| pix_oe | output | 1 | Pad drive enable for the data outputs |

## Verification
A wrong phase counter or misaligned shift registers show up at once as rotated or mixed bits in every word after lock. The bench compares each word against its arithmetic source, so the first check after lock catches this. A faulty lock counter moves the cycle in which `pix_word` leaves or returns to zero by at least one period, and the bench places its checks on both sides of each expected transition. A latency or edge-select error shifts the word stream by one or more checks within the first period after lock.

// File: rtl/desr_pkg.sv
// Shared types for the seven-to-one deserializer.
package desr_pkg;
    typedef enum logic [1:0] {
        LK_SEARCH  = 2'd0,
        LK_CONFIRM = 2'd1,
        LK_LOCKED  = 2'd2
    } lock_st_t;
endpackage

// File: rtl/desr_frame_lock.sv
// Framing-lane aligner. Keeps the last BITS framing bits and, while searching,
// checks every cycle whether they equal FRAME_PAT. On a hit the phase counter
// restarts, and LOCK_N consecutive hits at the period end declare lock.
// UNLOCK_N consecutive misses while locked fall back to search.
// Assumes LOCK_N >= 2, UNLOCK_N >= 1, and that the pattern differs from all
// of its rotations.
module desr_frame_lock
    import desr_pkg::*;
#(
    parameter int              BITS      = 7,
    parameter logic [BITS-1:0] FRAME_PAT = 7'b1100011,
    parameter int              LOCK_N    = 3,
    parameter int              UNLOCK_N  = 3,
    parameter int              PH_W      = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            frm_bit,
    output logic [PH_W-1:0] phase,
    output logic            strobe,
    output logic            locked
);
    localparam int CNT_MAX = (LOCK_N > UNLOCK_N) ? LOCK_N : UNLOCK_N;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BITS - 1);

    logic [BITS-2:0]  hist;
    logic [BITS-1:0]  window;
    logic             hit;
    logic             at_last;
    lock_st_t         st;
    logic [CNT_W-1:0] cnt;

    assign window  = {hist, frm_bit};
    assign hit     = (window == FRAME_PAT);
    assign at_last = (phase == PH_LAST);
    assign strobe  = at_last || (st == LK_SEARCH && hit);
    assign locked  = (st == LK_LOCKED);

    // Purpose: framing history, phase counter and lock state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist  <= '0;
            phase <= '0;
            st    <= LK_SEARCH;
            cnt   <= '0;
        end else begin
            hist  <= window[BITS-2:0];
            phase <= at_last ? '0 : phase + 1'b1;
            unique case (st)
                LK_SEARCH: begin
                    if (hit) begin
                        phase <= '0;
                        cnt   <= CNT_W'(1);
                        st    <= LK_CONFIRM;
                    end
                end
                LK_CONFIRM: begin
                    if (at_last) begin
                        if (!hit) begin
                            st  <= LK_SEARCH;
                            cnt <= '0;
                        end else if (cnt == CNT_W'(LOCK_N - 1)) begin
                            st  <= LK_LOCKED;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                LK_LOCKED: begin
                    if (at_last) begin
                        if (hit) begin
                            cnt <= '0;
                        end else if (cnt == CNT_W'(UNLOCK_N - 1)) begin
                            st  <= LK_SEARCH;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: st <= LK_SEARCH;
            endcase
        end
    end

    // Lock may only be entered right after a matching framing window.
    assert_lock_after_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(hit));

    // Lock may only be lost after a mismatch or an inactive request.
    assert_drop_after_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(!hit) || $past(clr)));

    // The miss counter never reaches the drop threshold while locked.
    assert_miss_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_LOCKED) |-> (cnt < CNT_W'(UNLOCK_N)));
endmodule

// File: rtl/desr_lane.sv
// One serial data lane: a BITS-deep shift register that takes the MSB first.
// The full group is captured when the aligner flags the period's last bit.
// Assumes strobe is high in the cycle that carries bit 0.
module desr_lane #(
    parameter int BITS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            din,
    input  logic            strobe,
    output logic [BITS-1:0] group
);
    logic [BITS-2:0] hist;
    logic [BITS-1:0] nxt;

    assign nxt = {hist, din};

    // Purpose: shift in serial bits and capture a full group at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist  <= '0;
            group <= '0;
        end else begin
            hist <= nxt[BITS-2:0];
            if (strobe) group <= nxt;
        end
    end

    // A captured group stays put between boundaries.
    assert_group_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !clr) |=> $stable(group));
endmodule

// File: rtl/desr_launch.sv
// Output pipeline. Captured words move into a middle stage at each boundary.
// The output register then takes the middle stage either at the boundary
// (pixel-clock rise) or at the end of the high phase (pixel-clock fall).
// Assumes edge_sel is static while the block is locked.
module desr_launch #(
    parameter int WIDTH     = 35,
    parameter int HI_PHASES = 4,
    parameter int PH_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] cap,
    input  logic             strobe,
    input  logic [PH_W-1:0]  phase,
    input  logic             edge_sel,
    output logic [WIDTH-1:0] held
);
    localparam logic [PH_W-1:0] PH_FALL = PH_W'(HI_PHASES - 1);

    logic [WIDTH-1:0] mid;
    logic             launch;

    assign launch = edge_sel ? strobe : (phase == PH_FALL);

    // Purpose: one-period delay stage followed by the edge-selected output load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mid  <= '0;
            held <= '0;
        end else begin
            if (strobe) mid  <= cap;
            if (launch) held <= mid;
        end
    end

    // Rising-edge mode: the word moves only at a boundary.
    assert_rise_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel && !strobe && !clr) |=> $stable(held));

    // Falling-edge mode: the word moves only at the end of the high phase.
    assert_fall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_sel && phase != PH_FALL && !clr) |=> $stable(held));
endmodule

// File: rtl/desr_7to1.sv
// Top level of the seven-to-one deserializer. It joins the framing aligner,
// one shift lane per data lane and the output pipeline, and it gates the
// outputs on lock and on the inactive controls. Assumes all serial inputs
// are already sampled on clk, which runs at BITS times the pixel rate.
module desr_7to1
    import desr_pkg::*;
#(
    parameter int              LANES     = 5,
    parameter int              BITS      = 7,
    parameter int              HI_PHASES = 4,
    parameter int              LOCK_N    = 3,
    parameter int              UNLOCK_N  = 3,
    parameter logic [BITS-1:0] FRAME_PAT = 7'b1100011
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      ser_lane,
    input  logic                  ser_frame,
    input  logic                  edge_sel,
    input  logic                  pwr_on,
    input  logic                  out_en,
    input  logic                  rsvd_in,
    output logic [LANES*BITS-1:0] pix_word,
    output logic                  pix_clk,
    output logic                  pix_oe
);
    localparam int WIDTH = LANES * BITS;
    localparam int PH_W  = $clog2(BITS);

    logic             active;
    logic             clr;
    logic [PH_W-1:0]  phase;
    logic             strobe;
    logic             locked;
    logic [WIDTH-1:0] cap_flat;
    logic [WIDTH-1:0] held;

    assign active = pwr_on && !rsvd_in;
    assign clr    = !active;

    desr_frame_lock #(
        .BITS(BITS), .FRAME_PAT(FRAME_PAT),
        .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N), .PH_W(PH_W)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .clr(clr), .frm_bit(ser_frame),
        .phase(phase), .strobe(strobe), .locked(locked)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        desr_lane #(.BITS(BITS)) u_lane (
            .clk(clk), .rst_n(rst_n), .clr(clr), .din(ser_lane[g]),
            .strobe(strobe), .group(cap_flat[g*BITS +: BITS])
        );
    end

    desr_launch #(
        .WIDTH(WIDTH), .HI_PHASES(HI_PHASES), .PH_W(PH_W)
    ) u_launch (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap_flat),
        .strobe(strobe), .phase(phase), .edge_sel(edge_sel), .held(held)
    );

    // Purpose: gate the data and the pixel clock on activity and lock.
    always_comb begin
        pix_word = (active && locked) ? held : '0;
        pix_clk  = active && locked && (phase < PH_W'(HI_PHASES));
        pix_oe   = out_en;
    end

    // Power-down removes lock at the next edge.
    assert_pd_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !locked);

    // The reserved input removes lock at the next edge.
    assert_rsvd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_in |=> !locked);

    // The pixel clock rises only right after a period boundary.
    assert_clk_rise_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_clk) |-> $past(strobe));
endmodule

// File: tb/test_desr_7to1.sv
`timescale 1ns/1ps
module test_desr_7to1;
    localparam int W = 35;
    localparam logic [6:0] PAT = 7'b1100011;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   ser_lane = '0;
    logic         ser_frame = 1'b0;
    logic         edge_sel = 1'b1;
    logic         pwr_on = 1'b1;
    logic         out_en = 1'b1;
    logic         rsvd_in = 1'b0;
    logic [W-1:0] pix_word;
    logic         pix_clk;
    logic         pix_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int sc_cor_at, sc_cor_len, sc_pd_at, sc_pd_len, sc_oe_at, sc_oe_len;
    bit sc_rsvd;
    bit sc_es;

    always #2.5 clk = ~clk;

    desr_7to1 i_desr_7to1 (
        .clk(clk), .rst_n(rst_n), .ser_lane(ser_lane), .ser_frame(ser_frame),
        .edge_sel(edge_sel), .pwr_on(pwr_on), .out_en(out_en), .rsvd_in(rsvd_in),
        .pix_word(pix_word), .pix_clk(pix_clk), .pix_oe(pix_oe)
    );

    // Source word k: a walking one first, then fixed extremes and a hash.
    function automatic logic [W-1:0] word_of(input int k);
        logic [63:0] v;
        if (k < 0) return '0;
        if (k < W) return W'(1) << k;
        if (k == 40) return '1;
        if (k == 41) return '0;
        v = 64'(k) * 64'h9E3779B97F4A7C15;
        return v[34:0] ^ v[63:29];
    endfunction

    function automatic bit in_win(input int k, input int at, input int len);
        return (len > 0) && (k >= at) && (k < at + len);
    endfunction

    // Unlocked after the boundary of period m (rising-edge view).
    function automatic bit zero_r(input int m);
        return (m < 2)
            || (sc_cor_len >= 3 && m >= sc_cor_at + 2 && m < sc_cor_at + 5)
            || (sc_pd_len > 0 && m >= sc_pd_at && m < sc_pd_at + sc_pd_len + 2);
    endfunction

    // Output low after the falling launch edge of period m.
    function automatic bit zero_f(input int m);
        return (m <= 2)
            || (sc_cor_len >= 3 && m >= sc_cor_at + 3 && m <= sc_cor_at + 5)
            || (sc_pd_len > 0 && m >= sc_pd_at && m <= sc_pd_at + sc_pd_len + 2);
    endfunction

    function automatic string why(input int m);
        if (in_win(m, sc_pd_at, sc_pd_len + 3)) return sc_rsvd ? "R9" : "R8";
        if (in_win(m, sc_cor_at, sc_cor_len + 3)) return "R4";
        if (m <= 3) return "R3";
        return "R1 R2";
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input int i);
        int k;
        int p;
        logic [W-1:0] w;
        k = i / 7;
        p = i % 7;
        w = word_of(k);
        for (int l = 0; l < 5; l++) ser_lane[l] = w[l*7 + 6 - p];
        ser_frame = PAT[6 - p] ^ in_win(k, sc_cor_at, sc_cor_len);
        pwr_on    = !(in_win(k, sc_pd_at, sc_pd_len) && !sc_rsvd);
        rsvd_in   = in_win(k, sc_pd_at, sc_pd_len) && sc_rsvd;
        out_en    = !in_win(k, sc_oe_at, sc_oe_len);
    endtask

    // Check after the edge that sampled bit j of the stream.
    task automatic check(input int j);
        int m;
        int r;
        m = j / 7;
        r = j % 7;
        if (r == 6) begin
            chk({"R7 pix_clk at boundary ", why(m)}, W'(pix_clk), W'(!zero_r(m)));
            chk("R10 pix_oe", W'(pix_oe), W'(!in_win(m, sc_oe_at, sc_oe_len)));
            if (sc_es)
                chk({"R5 rising launch ", why(m)}, pix_word,
                    zero_r(m) ? '0 : word_of(m - 2));
        end
        if (r == 3) begin
            chk("R7 pix_clk low phase", W'(pix_clk), '0);
            if (!sc_es)
                chk({"R6 falling launch ", why(m)}, pix_word,
                    zero_f(m) ? '0 : word_of(m - 2));
            else
                chk({"R5 hold until rise ", why(m)}, pix_word,
                    (zero_r(m - 1) || in_win(m, sc_pd_at, sc_pd_len)) ? '0 : word_of(m - 3));
        end
    endtask

    task automatic run(input bit es, input int nw, input int cor_at, input int cor_len,
                       input int pd_at, input int pd_len, input bit use_rsvd,
                       input int oe_at, input int oe_len);
        sc_es = es;
        sc_cor_at = cor_at;  sc_cor_len = cor_len;
        sc_pd_at = pd_at;    sc_pd_len = pd_len;
        sc_rsvd = use_rsvd;
        sc_oe_at = oe_at;    sc_oe_len = oe_len;
        edge_sel = es;
        rst_n = 1'b0;
        ser_lane = '0; ser_frame = 1'b0; pwr_on = 1'b1; rsvd_in = 1'b0; out_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset word", pix_word, '0);
        chk("R11 reset pix_clk", W'(pix_clk), '0);
        rst_n = 1'b1;
        for (int i = 0; i <= nw * 7; i++) begin
            if (i > 0) begin
                @(negedge clk);
                check(i - 1);
            end
            if (i < nw * 7) drive(i);
        end
    endtask

    initial begin
        run(1'b1, 60, -100, 0, -100, 0, 1'b0, -100, 0);
        run(1'b0, 60, -100, 0, -100, 0, 1'b0, -100, 0);
        run(1'b1, 60, 20, 2, -100, 0, 1'b0, -100, 0);
        run(1'b0, 60, 20, 3, -100, 0, 1'b0, -100, 0);
        run(1'b1, 60, 30, 3, -100, 0, 1'b0, -100, 0);
        run(1'b1, 60, -100, 0, 25, 4, 1'b0, -100, 0);
        run(1'b0, 60, -100, 0, 25, 4, 1'b1, -100, 0);
        run(1'b1, 60, -100, 0, -100, 0, 1'b0, 10, 5);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule